// File: doc/BRIEF.md
# Pin Ownership and Drive Control Bank

This block holds the configuration of a bank of pins (32 by default) and works out, for every pin, what the pad drives. Each pin is owned either by the general-purpose I/O logic or by one of four peripheral functions. Software changes most settings through paired strobe addresses. A write to a "set" address raises the bits marked 1 in the written mask. A write to the matching "clear" address lowers them. Every pair has a read-only status view.

The peripheral choice is a two-bit code per pin. It is spread across two plain read/write bit-planes: the low plane holds the code LSB and the high plane holds the MSB. Open-drain drive limits a pin to pulling low or releasing the pad. The pad input is resynchronised and can always be read back, whoever owns the pin. Interrupt detection, input filtering and analog behaviour belong to other blocks.

Top module: `gpio_mux_bank`

## Requirements
- R1: After reset every pin is owned by GPIO, output enable is off, output data is 0, open-drain is off, pull-up is on, pull-down is off, and both selector planes read 0.
- R2: For each of the six strobe pairs, a write to the set address sets exactly the bits that are 1 in the data. A write to the clear address clears exactly those bits. All other bits keep their value, and the status address reads the result one cycle later. The field numbers are ownership=0, output enable=1, output data=2, open-drain=3, pull-up=4, pull-down=5. For field f, the set, clear and status addresses are 3f, 3f+1 and 3f+2.
- R3: On a GPIO-owned pin, the pad output enable follows the output-enable status and the pad output follows the output-data status.
- R4: On a peripheral-owned pin, the code {high plane, low plane} chooses the source of the pad output and pad enable: 00 picks function A, 01 B, 10 C and 11 D.
- R5: The low selector plane (address 18) and the high plane (address 19) store the written word whole and read it back. They change only when written.
- R6: With open-drain on, the pad output is 0 and the pad enable is the chosen enable ANDed with the inverse of the chosen data. This applies both to GPIO-owned and to peripheral-owned pins.
- R7: Address 20 reads the pad input as it stood two clock edges earlier, whatever the ownership.
- R8: The pull-up and pull-down status drive the pad pull controls directly, and neither one changes the other.
- R9: Writes to a status address, to address 20 or to an unused address change nothing. Reads of set or clear addresses and of unused addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | NPIN | Write data / bit mask |
| rd_addr | input | AW | Read address |
| rd_data | output | NPIN | Read data, combinational |
| fa_out | input | NPIN | Function A output data |
| fa_oe | input | NPIN | Function A output enable |
| fb_out | input | NPIN | Function B output data |
| fb_oe | input | NPIN | Function B output enable |
| fc_out | input | NPIN | Function C output data |
| fc_oe | input | NPIN | Function C output enable |
| fd_out | input | NPIN | Function D output data |
| fd_oe | input | NPIN | Function D output enable |
| pad_in | input | NPIN | Pad input level |
| pad_out | output | NPIN | Pad output data |
| pad_oe | output | NPIN | Pad output enable |
| pad_pu | output | NPIN | Pad pull-up enable |
| pad_pd | output | NPIN | Pad pull-down enable |

## Verification
A corrupted strobe register shows up on the next clock edge, on the pad outputs or on a status readback. A wrong selector decode or a wrong open-drain gating shows up in the same cycle on pad_out or pad_oe, as soon as function sources with differing bit patterns are applied. A synchronizer with the wrong depth puts the level readback one edge early or late, so any pad input toggle gives it away within three cycles. A reference model is compared against every output and against a rotating read address on every clock, so each of these faults surfaces within a few cycles.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int NUM_SC     = 6;
  localparam int F_OWN      = 0;
  localparam int F_OE       = 1;
  localparam int F_DAT      = 2;
  localparam int F_OD       = 3;
  localparam int F_PU       = 4;
  localparam int F_PD       = 5;
  localparam int ADDR_SEL_LO = 3 * NUM_SC;
  localparam int ADDR_SEL_HI = 3 * NUM_SC + 1;
  localparam int ADDR_LEVEL  = 3 * NUM_SC + 2;

  function automatic int set_addr(input int f);
    return 3 * f;
  endfunction

  function automatic int clr_addr(input int f);
    return 3 * f + 1;
  endfunction

  function automatic int stat_addr(input int f);
    return 3 * f + 2;
  endfunction

  // code {hi,lo}: 0=A 1=B 2=C 3=D
  function automatic logic pick4(input logic [1:0] code, input logic [3:0] src);
    return src[code];
  endfunction
endpackage

// File: rtl/gpio_sc_reg.sv
module gpio_sc_reg #(
  parameter int   W       = 32,
  parameter logic RST_ONE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= {W{RST_ONE}};
    else        q_o <= (q_o | set_i) & ~clr_i;
  end

  // R2: marked bits are raised after a set strobe
  p_set_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((q_o & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i)));

  // R2: bits not named by either strobe hold
  p_keep_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((q_o & ~$past(set_i | clr_i)) == ($past(q_o) & ~$past(set_i | clr_i))));
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta;
  logic [1:0]   age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q_o  <= '0;
    end else begin
      meta <= d_i;
      q_o  <= meta;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  // R7: readback lags the pad by two edges
  p_sync_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] own_i,
  input  logic [W-1:0] oe_i,
  input  logic [W-1:0] dat_i,
  input  logic [W-1:0] od_i,
  input  logic [W-1:0] sel_lo_i,
  input  logic [W-1:0] sel_hi_i,
  input  logic [W-1:0] fa_out,
  input  logic [W-1:0] fa_oe,
  input  logic [W-1:0] fb_out,
  input  logic [W-1:0] fb_oe,
  input  logic [W-1:0] fc_out,
  input  logic [W-1:0] fc_oe,
  input  logic [W-1:0] fd_out,
  input  logic [W-1:0] fd_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  // chosen source per pin, brought out for the checks
  logic [W-1:0] src_dat;
  logic [W-1:0] src_oe;

  for (genvar k = 0; k < W; k++) begin : g_pin
    logic [1:0] code;
    logic       p_dat;
    logic       p_oe;
    assign code  = {sel_hi_i[k], sel_lo_i[k]};
    assign p_dat = pick4(code, {fd_out[k], fc_out[k], fb_out[k], fa_out[k]});
    assign p_oe  = pick4(code, {fd_oe[k], fc_oe[k], fb_oe[k], fa_oe[k]});

    always_comb begin
      src_dat[k] = own_i[k] ? dat_i[k] : p_dat;
      src_oe[k]  = own_i[k] ? oe_i[k]  : p_oe;
      if (od_i[k]) begin
        pad_out[k] = 1'b0;
        pad_oe[k]  = src_oe[k] & ~src_dat[k];
      end else begin
        pad_out[k] = src_dat[k];
        pad_oe[k]  = src_oe[k];
      end
    end
  end

  // R6: an open-drain pin never drives high
  p_odrain_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & od_i) == '0));

  // R6: an open-drain pin is released whenever its data is 1
  p_odrain_rel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & od_i & src_dat) == '0));
endmodule

// File: rtl/gpio_mux_bank.sv
module gpio_mux_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPIN = 32,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [NPIN-1:0] wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [NPIN-1:0] rd_data,
  input  logic [NPIN-1:0] fa_out,
  input  logic [NPIN-1:0] fa_oe,
  input  logic [NPIN-1:0] fb_out,
  input  logic [NPIN-1:0] fb_oe,
  input  logic [NPIN-1:0] fc_out,
  input  logic [NPIN-1:0] fc_oe,
  input  logic [NPIN-1:0] fd_out,
  input  logic [NPIN-1:0] fd_oe,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_pu,
  output logic [NPIN-1:0] pad_pd
);
  logic [NPIN-1:0] sc_set [NUM_SC];
  logic [NPIN-1:0] sc_clr [NUM_SC];
  logic [NPIN-1:0] sc_q   [NUM_SC];
  logic [NPIN-1:0] sel_lo, sel_hi, level;
  logic            wr_sel_lo, wr_sel_hi;

  for (genvar f = 0; f < NUM_SC; f++) begin : g_sc
    assign sc_set[f] = (wr_en && wr_addr == AW'(set_addr(f))) ? wr_data : '0;
    assign sc_clr[f] = (wr_en && wr_addr == AW'(clr_addr(f))) ? wr_data : '0;
    gpio_sc_reg #(
      .W       (NPIN),
      .RST_ONE ((f == F_OWN) || (f == F_PU))
    ) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (sc_set[f]),
      .clr_i (sc_clr[f]),
      .q_o   (sc_q[f])
    );
  end

  assign wr_sel_lo = wr_en && (wr_addr == AW'(ADDR_SEL_LO));
  assign wr_sel_hi = wr_en && (wr_addr == AW'(ADDR_SEL_HI));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_lo <= '0;
      sel_hi <= '0;
    end else begin
      if (wr_sel_lo) sel_lo <= wr_data;
      if (wr_sel_hi) sel_hi <= wr_data;
    end
  end

  // R5: selector planes move only on their own write
  p_sel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_sel_lo && !wr_sel_hi) |=> ($stable(sel_lo) && $stable(sel_hi)));

  gpio_sync2 #(.W(NPIN)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pad_in),
    .q_o   (level)
  );

  gpio_pad_mux #(.W(NPIN)) u_mux (
    .clk      (clk),
    .rst_n    (rst_n),
    .own_i    (sc_q[F_OWN]),
    .oe_i     (sc_q[F_OE]),
    .dat_i    (sc_q[F_DAT]),
    .od_i     (sc_q[F_OD]),
    .sel_lo_i (sel_lo),
    .sel_hi_i (sel_hi),
    .fa_out   (fa_out),
    .fa_oe    (fa_oe),
    .fb_out   (fb_out),
    .fb_oe    (fb_oe),
    .fc_out   (fc_out),
    .fc_oe    (fc_oe),
    .fd_out   (fd_out),
    .fd_oe    (fd_oe),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
  );

  assign pad_pu = sc_q[F_PU];
  assign pad_pd = sc_q[F_PD];

  always_comb begin
    rd_data = '0;
    for (int f = 0; f < NUM_SC; f++)
      if (rd_addr == AW'(stat_addr(f))) rd_data = sc_q[f];
    if (rd_addr == AW'(ADDR_SEL_LO)) rd_data = sel_lo;
    if (rd_addr == AW'(ADDR_SEL_HI)) rd_data = sel_hi;
    if (rd_addr == AW'(ADDR_LEVEL))  rd_data = level;
  end
endmodule

// File: tb/gpio_mux_bank_bench.sv
module gpio_mux_bank_bench;
  localparam int N = 32;
  localparam int A = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [A-1:0] wr_addr = '0, rd_addr = '0;
  logic [N-1:0] wr_data = '0;
  logic [N-1:0] rd_data;
  logic [N-1:0] fa_out = '0, fa_oe = '0, fb_out = '0, fb_oe = '0;
  logic [N-1:0] fc_out = '0, fc_oe = '0, fd_out = '0, fd_oe = '0;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_out, pad_oe, pad_pu, pad_pd;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_mux_bank u_gpio_mux_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .fa_out(fa_out), .fa_oe(fa_oe), .fb_out(fb_out), .fb_oe(fb_oe),
    .fc_out(fc_out), .fc_oe(fc_oe), .fd_out(fd_out), .fd_oe(fd_oe),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .pad_pd(pad_pd));

  // reference state: fields 0..5 as in R2, then selector planes and pad history
  logic [N-1:0] m_f [6];
  logic [N-1:0] m_lo, m_hi, h1, h2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_f[0] <= '1; m_f[1] <= '0; m_f[2] <= '0;
      m_f[3] <= '0; m_f[4] <= '1; m_f[5] <= '0;
      m_lo <= '0; m_hi <= '0; h1 <= '0; h2 <= '0;
    end else begin
      h1 <= pad_in;
      h2 <= h1;
      if (wr_en) begin
        int a;
        a = int'(wr_addr);
        if (a < 18 && (a % 3) != 2) begin
          logic [N-1:0] t;
          t = m_f[a / 3];
          for (int k = 0; k < N; k++)
            if (wr_data[k]) t[k] = ((a % 3) == 0);
          m_f[a / 3] <= t;
        end else if (a == 18) m_lo <= wr_data;
        else if (a == 19) m_hi <= wr_data;
      end
    end
  end

  function automatic logic [N-1:0] exp_read(input int a);
    if (a < 18 && (a % 3) == 2) return m_f[a / 3];
    if (a == 18) return m_lo;
    if (a == 19) return m_hi;
    if (a == 20) return h2;
    return '0;
  endfunction

  function automatic logic [1:0] exp_pin(input int k);
    logic d, e;
    int c;
    if (m_f[0][k]) begin
      d = m_f[2][k]; e = m_f[1][k];
    end else begin
      c = 2 * int'(m_hi[k]) + int'(m_lo[k]);
      case (c)
        0: begin d = fa_out[k]; e = fa_oe[k]; end
        1: begin d = fb_out[k]; e = fb_oe[k]; end
        2: begin d = fc_out[k]; e = fc_oe[k]; end
        default: begin d = fd_out[k]; e = fd_oe[k]; end
      endcase
    end
    if (m_f[3][k]) return {1'b0, e & ~d};
    return {d, e};
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the edge
  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      logic [N-1:0] eo, ee;
      int a;
      for (int k = 0; k < N; k++) begin
        logic [1:0] p;
        p = exp_pin(k);
        eo[k] = p[1];
        ee[k] = p[0];
      end
      chk("R3/R4/R6 pad_out", pad_out, eo);
      chk("R3/R4/R6 pad_oe", pad_oe, ee);
      chk("R8 pad_pu", pad_pu, m_f[4]);
      chk("R8 pad_pd", pad_pd, m_f[5]);
      a = int'(rd_addr);
      if (a == 18 || a == 19) chk("R5 read", rd_data, exp_read(a));
      else if (a == 20) chk("R7 read", rd_data, exp_read(a));
      else if (a < 18 && (a % 3) == 2) chk("R2 read", rd_data, exp_read(a));
      else chk("R9 read", rd_data, exp_read(a));
    end
  end

  task automatic wr(input int a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = A'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input string tag, input logic [N-1:0] exp);
    @(negedge clk);
    rd_addr = A'(a);
    #1;
    chk(tag, rd_data, exp);
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(2,  "R1 own", '1);
    rd(5,  "R1 oe", '0);
    rd(8,  "R1 dat", '0);
    rd(11, "R1 od", '0);
    rd(14, "R1 pu", '1);
    rd(17, "R1 pd", '0);
    rd(18, "R1 sel_lo", '0);
    rd(19, "R1 sel_hi", '0);

    // R2 masked set/clear
    wr(3, 32'h0000_FF0F);
    wr(4, 32'h0000_0F00);
    rd(5, "R2 oe", 32'h0000_F00F);
    wr(6, 32'hFFFF_FFFF);
    wr(7, 32'h5555_5555);
    rd(8, "R2 dat", 32'hAAAA_AAAA);
    @(negedge clk);
    chk("R3 pad_out", pad_out, 32'hAAAA_AAAA);
    chk("R3 pad_oe", pad_oe, 32'h0000_F00F);

    // R4 peripheral codes
    fa_out = 32'h1111_1111; fb_out = 32'h2222_2222;
    fc_out = 32'h4444_4444; fd_out = 32'h8888_8888;
    fa_oe = 32'hF000_0000; fb_oe = 32'h0F00_0000;
    fc_oe = 32'h00F0_0000; fd_oe = 32'h000F_0000;
    wr(1, '1);
    wr(18, '0); wr(19, '0);
    @(negedge clk); chk("R4 code A", pad_out, 32'h1111_1111); chk("R4 code A oe", pad_oe, 32'hF000_0000);
    wr(18, '1);
    @(negedge clk); chk("R4 code B", pad_out, 32'h2222_2222);
    wr(18, '0); wr(19, '1);
    @(negedge clk); chk("R4 code C", pad_out, 32'h4444_4444);
    wr(18, '1);
    @(negedge clk); chk("R4 code D", pad_out, 32'h8888_8888); chk("R4 code D oe", pad_oe, 32'h000F_0000);
    rd(19, "R5 sel_hi", '1);

    // R6 open drain on GPIO pins
    wr(0, '1); wr(3, '1); wr(9, 32'h0000_FFFF);
    @(negedge clk);
    chk("R6 od out", pad_out, 32'hAAAA_0000);
    chk("R6 od oe", pad_oe, 32'hFFFF_5555);

    // R8 pulls independent
    wr(15, '1);
    rd(14, "R8 pu kept", '1);
    chk("R8 pd on", pad_pd, '1);
    wr(13, 32'h0000_00FF);
    chk("R8 pu off", pad_pu, 32'hFFFF_FF00);

    // R9 ignored writes
    wr(5, '0); wr(20, '0); wr(23, '1);
    rd(5, "R9 oe kept", '1);
    rd(23, "R9 unused read", '0);
    rd(3, "R9 set read", '0);

    // R7 level readback
    rd_addr = A'(20);
    @(negedge clk); pad_in = 32'hCAFE_F00D;
    @(negedge clk); chk("R7 one edge", rd_data, 32'h0);
    @(negedge clk); chk("R7 two edges", rd_data, 32'hCAFE_F00D);

    // mixed traffic, model compared every cycle
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      wr_en   = ($urandom_range(0, 2) != 0);
      wr_addr = A'($urandom_range(0, 23));
      wr_data = $urandom();
      rd_addr = A'($urandom_range(0, 23));
      pad_in  = $urandom();
      if ((i % 7) == 0) begin
        fa_out = $urandom(); fb_out = $urandom(); fc_out = $urandom(); fd_out = $urandom();
        fa_oe = $urandom(); fb_oe = $urandom(); fc_oe = $urandom(); fd_oe = $urandom();
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule